// File: doc/BRIEF.md
# Byte-Lane Static RAM Interface

A word-wide static memory behind a pin-style control set: all controls are active low. One select pin turns the part on. One write strobe and one output gate pick the operation. Two lane enables pick which byte of the 16-bit word takes part. Every control pin is sampled on the rising edge of a system clock. On that same edge, a write updates the enabled bytes of the addressed word. A read registers the enabled bytes, and they appear on the outputs one clock later.

There is no tri-state pin. The block has a separate input word (`din`), a separate output word (`dout`) and a two-bit drive-enable (`dout_oe`), one bit per byte lane. The surrounding pad logic can then build a bidirectional bus from them. The storage depth is set by the address width parameter. Its default is kept small so the block elaborates quickly; the full organization uses 17 address bits.

A control state machine decodes the sampled pins into one of four named states:
- STANDBY: the select pin is high.
- IDLE: the part is selected with neither strobe active.
- READ: selected, write strobe high, output gate low.
- WRITE: selected, write strobe low.

The next state is decoded afresh from the pins on every edge. Every state can therefore reach every other in one cycle. The transitions are named by their causes:
- to STANDBY: the select pin rises.
- to WRITE: the part is selected and the write strobe falls.
- to READ: the part is selected, the output gate is low and the write strobe is high.
- to IDLE: the part is selected and both strobes are high.

The drive-enable comes from the registered state: it is non-zero only in READ.

Top module: `lane_sram`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `dout_oe` is 2'b00 and `dout` is zero; memory contents are not initialized.
- R2: A write happens on an edge where `ce_n`=0 and `we_n`=0; bits 7..0 of `din` are stored into the low byte of word `addr` only if `lo_n`=0.
- R3: Bits 15..8 of `din` are stored into the high byte only if `hi_n`=0, independently of the low lane; a lane whose enable is high during a write keeps its old byte.
- R4: A read is sampled when `ce_n`=0, `oe_n`=0 and `we_n`=1; one cycle later `dout_oe[0]` equals the inverse of the sampled `lo_n`, `dout_oe[1]` equals the inverse of the sampled `hi_n`, and each driven lane carries the stored byte of the sampled address.
- R5: One cycle after an edge with `ce_n`=1, `oe_n`=1, or both `lo_n` and `hi_n` at 1, `dout_oe` is 2'b00.
- R6: Write has priority: with `ce_n`=0 and `we_n`=0 the level of `oe_n` is ignored, the write is performed and `dout_oe` is 2'b00 the next cycle.
- R7: With `ce_n`=1 all other controls are ignored: no byte of memory changes, even when `we_n` is low.
- R8: Output bits of a lane whose `dout_oe` bit is 0 are zero.
- R9: Each of the 2^AW addresses, including the highest, selects a distinct word; there is no aliasing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; controls are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the control and output registers |
| ce_n | input | 1 | Active-low select; high means standby |
| we_n | input | 1 | Active-low write strobe |
| oe_n | input | 1 | Active-low output gate |
| lo_n | input | 1 | Active-low enable of byte lane 0 (bits 7..0) |
| hi_n | input | 1 | Active-low enable of byte lane 1 (bits 15..8) |
| addr | input | AW | Word address |
| din | input | 16 | Write data from the bus |
| dout | output | 16 | Read data toward the bus |
| dout_oe | output | 2 | Per-lane drive enable; bit 0 covers bits 7..0, bit 1 covers bits 15..8 |

## Verification
The bench builds the block with AW=4, a 16-word array. Every word, including the highest address, is written, overwritten and read back many times, and random traffic falls on already-written words. Some random cycles leave the write strobe and output gate low together, and some set both lane enables high. That lets the behavioural model predict every data bit and drive-enable bit on every clock.

// File: rtl/lane_sram_pkg.sv
package lane_sram_pkg;

    localparam int LANES  = 2;
    localparam int LANE_W = 8;
    localparam int WORD_W = LANES * LANE_W;

    typedef enum logic [1:0] {
        ST_STANDBY = 2'd0,
        ST_IDLE    = 2'd1,
        ST_READ    = 2'd2,
        ST_WRITE   = 2'd3
    } sram_state_e;

endpackage

// File: rtl/lane_sram_ctrl.sv
module lane_sram_ctrl
    import lane_sram_pkg::*;
#(
    parameter int NLANE = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ce_n,
    input  logic             we_n,
    input  logic             oe_n,
    input  logic [NLANE-1:0] lane_n,
    output logic [NLANE-1:0] wr_lane,
    output logic [NLANE-1:0] rd_lane,
    output logic [NLANE-1:0] oe_lane
);

    sram_state_e      state_d, state_q;
    logic [NLANE-1:0] lane_q;

    // decode of the sampled pins; deselect dominates, then write
    always_comb begin
        if (ce_n)       state_d = ST_STANDBY;
        else if (!we_n) state_d = ST_WRITE;
        else if (!oe_n) state_d = ST_READ;
        else            state_d = ST_IDLE;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_STANDBY;
            lane_q  <= '1;
        end else begin
            state_q <= state_d;
            lane_q  <= lane_n;
        end
    end

    // outputs: strobes for the current edge, drive enable from the registered state
    always_comb begin
        wr_lane = '0;
        rd_lane = '0;
        unique case (state_d)
            ST_WRITE:   wr_lane = ~lane_n;
            ST_READ:    rd_lane = ~lane_n;
            ST_IDLE,
            ST_STANDBY: ;
            default:    ;
        endcase
        oe_lane = '0;
        unique case (state_q)
            ST_READ:    oe_lane = ~lane_q;
            ST_WRITE,
            ST_IDLE,
            ST_STANDBY: ;
            default:    ;
        endcase
    end

endmodule

// File: rtl/lane_sram_bank.sv
module lane_sram_bank #(
    parameter int AW     = 10,
    parameter int BYTE_W = 8,
    parameter int NLANE  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [AW-1:0]           addr,
    input  logic [NLANE*BYTE_W-1:0] din,
    input  logic [NLANE-1:0]        wr_lane,
    input  logic [NLANE-1:0]        rd_lane,
    output logic [NLANE*BYTE_W-1:0] dout
);

    localparam int DEPTH = 1 << AW;

    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        logic [BYTE_W-1:0] store [DEPTH];
        logic [BYTE_W-1:0] rdata_q;

        always_ff @(posedge clk) begin
            if (wr_lane[g]) store[addr] <= din[g*BYTE_W +: BYTE_W];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          rdata_q <= '0;
            else if (rd_lane[g]) rdata_q <= store[addr];
            else                 rdata_q <= '0;
        end

        assign dout[g*BYTE_W +: BYTE_W] = rdata_q;
    end

endmodule

// File: rtl/lane_sram.sv
module lane_sram
    import lane_sram_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic              lo_n,
    input  logic              hi_n,
    input  logic [AW-1:0]     addr,
    input  logic [WORD_W-1:0] din,
    output logic [WORD_W-1:0] dout,
    output logic [LANES-1:0]  dout_oe
);

    logic [LANES-1:0] wr_lane, rd_lane;

    lane_sram_ctrl #(.NLANE(LANES)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .ce_n    (ce_n),
        .we_n    (we_n),
        .oe_n    (oe_n),
        .lane_n  ({hi_n, lo_n}),
        .wr_lane (wr_lane),
        .rd_lane (rd_lane),
        .oe_lane (dout_oe)
    );

    lane_sram_bank #(.AW(AW), .BYTE_W(LANE_W), .NLANE(LANES)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (addr),
        .din     (din),
        .wr_lane (wr_lane),
        .rd_lane (rd_lane),
        .dout    (dout)
    );

endmodule

// File: rtl/lane_sram_chk.sv
module lane_sram_chk #(
    parameter int AW = 10
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ce_n,
    input logic          we_n,
    input logic          oe_n,
    input logic          lo_n,
    input logic          hi_n,
    input logic [15:0]   dout,
    input logic [1:0]    dout_oe
);

    // R4
    drive_needs_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_oe != 2'b00) |-> $past(!ce_n && !oe_n && we_n));

    // R4
    lane_lo_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dout_oe[0] |-> $past(!lo_n));

    // R4
    lane_hi_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dout_oe[1] |-> $past(!hi_n));

    // R5
    bus_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ce_n || oe_n || (lo_n && hi_n)) |-> (dout_oe == 2'b00));

    // R6
    write_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!ce_n && !we_n) |-> (dout_oe == 2'b00));

    // R8
    quiet_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_oe[0] |-> (dout[7:0] == 8'h00));

    // R8
    quiet_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_oe[1] |-> (dout[15:8] == 8'h00));

endmodule

bind lane_sram lane_sram_chk #(.AW(AW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ce_n    (ce_n),
    .we_n    (we_n),
    .oe_n    (oe_n),
    .lo_n    (lo_n),
    .hi_n    (hi_n),
    .dout    (dout),
    .dout_oe (dout_oe)
);

// File: tb/sim_lane_sram.sv
module sim_lane_sram;

    localparam int AW    = 4;
    localparam int WORDS = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, lo_n = 1'b1, hi_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [15:0]   din = '0;
    logic [15:0]   dout;
    logic [1:0]    dout_oe;

    int checks = 0;
    int fails  = 0;

    logic [15:0] model [WORDS];

    always #2 clk = ~clk;

    lane_sram #(.AW(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .lo_n(lo_n), .hi_n(hi_n), .addr(addr), .din(din),
        .dout(dout), .dout_oe(dout_oe)
    );

    task automatic check16(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // one cycle: drive at negedge, sample at the following negedge
    task automatic cyc(input logic c, input logic w, input logic o, input logic l,
                       input logic h, input int a, input logic [15:0] d, input string rtag);
        logic        sel, wr, rd;
        logic [1:0]  eoe;
        logic [15:0] edo;
        string       otag;
        ce_n = c; we_n = w; oe_n = o; lo_n = l; hi_n = h;
        addr = AW'(a); din = d;
        sel = !c;
        wr  = sel && !w;
        rd  = sel && w && !o;
        eoe = rd ? {!h, !l} : 2'b00;
        edo = 16'h0000;
        if (eoe[0]) edo[7:0]  = model[a][7:0];
        if (eoe[1]) edo[15:8] = model[a][15:8];
        if (rd)             otag = "R4";
        else if (c && !w)   otag = "R7";
        else if (wr && !o)  otag = "R6";
        else                otag = "R5";
        @(posedge clk);
        if (wr && !l) model[a][7:0]  = d[7:0];
        if (wr && !h) model[a][15:8] = d[15:8];
        @(negedge clk);
        check16({otag, " drive enable"}, {14'h0, dout_oe}, {14'h0, eoe});
        check16(eoe[0] ? {rtag, " low lane"}  : "R8 low lane",  {8'h0, dout[7:0]},  {8'h0, edo[7:0]});
        check16(eoe[1] ? {rtag, " high lane"} : "R8 high lane", {8'h0, dout[15:8]}, {8'h0, edo[15:8]});
    endtask

    task automatic rd_word(input int a, input string tag);
        cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, a, 16'hxxxx, tag);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual expired expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : stim
        for (int i = 0; i < WORDS; i++) model[i] = 16'h0000;
        repeat (3) @(negedge clk);
        // R1: outputs quiet during reset
        check16("R1 reset drive enable", {14'h0, dout_oe}, 16'h0);
        check16("R1 reset data", dout, 16'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check16("R1 first cycle drive enable", {14'h0, dout_oe}, 16'h0);
        check16("R1 first cycle data", dout, 16'h0);

        // fill every word, both lanes (R9)
        for (int a = 0; a < WORDS; a++)
            cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, a, 16'(16'hA500 + a * 16'h0111), "R9");
        for (int a = 0; a < WORDS; a++) rd_word(a, "R9");
        rd_word(WORDS - 1, "R9 top");

        // R2: low lane only
        cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 3, 16'h1234, "R2");
        rd_word(3, "R2");
        // R3: high lane only, low kept
        cyc(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 5, 16'hBEEF, "R3");
        rd_word(5, "R3");
        // R3: neither lane written
        cyc(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 6, 16'hDEAD, "R3");
        rd_word(6, "R3");
        // R7: deselected write attempt
        cyc(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 7, 16'h0F0F, "R7");
        rd_word(7, "R7");
        // R6: write with output gate low
        cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8, 16'hC3C3, "R6");
        rd_word(8, "R6");
        // R4: single-lane reads
        cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 8, 16'h0, "R4 low only");
        cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 8, 16'h0, "R4 high only");
        // R5: release conditions
        cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 8, 16'h0, "R5");
        cyc(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8, 16'h0, "R5");
        cyc(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8, 16'h0, "R5");
        // R9: top and bottom words distinct
        cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 0, 16'h0001, "R9");
        cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, WORDS - 1, 16'hFFFE, "R9");
        rd_word(0, "R9 bottom");
        rd_word(WORDS - 1, "R9 top");

        // random traffic
        for (int n = 0; n < 3000; n++) begin
            logic [5:0] r;
            r = 6'($urandom);
            cyc(r[0] & r[1], r[2], r[3], r[4], r[5], int'($urandom % WORDS),
                16'($urandom), "R4 random");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule